// File: doc/BRIEF.md
# ADC Conversion Sequencer with Result Byte Registers

This block is the digital control half of a 10-bit successive-approximation converter that sits on a byte-wide register bus. Software sets the converter on, picks an input channel and asks for a conversion. The block then counts ticks of the converter clock to frame that conversion. When the conversion ends, it captures the converter's 10-bit output from a plain input port and raises a completion flag, which can also drive an interrupt line.

A conversion can run once per request, or it can repeat back to back until software stops it. The first conversion after the converter is switched on runs through a longer initialization span. The channel that feeds the analog multiplexer changes only between conversions.

The stored result is read as two bytes, with right or left justification. Reading the low byte freezes the stored result until the high byte has also been read, so the two halves always come from the same sample.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every register reads 0x00, `irq` is 0 and `chan_sel` is 0.
- R2: A conversion that is not the first one since enabling completes on the 13th `adc_tick` seen after the start-bit write (NORM_CYC).
- R3: The first conversion after the enable bit goes from 0 to 1 completes on the 25th tick (INIT_CYC). This holds whether the start is written together with the enable or in a later write.
- R4: In single mode the start bit (control bit 1) reads 1 while a conversion runs and reads 0 once it ends. No further conversion begins without another write of 1 to it, and writing it while busy has no effect.
- R5: With the free-run bit (control bit 2) set, one start gives conversions that repeat exactly 13 ticks apart while the start bit stays 1. Clearing free-run lets the current conversion finish, and the block then stops.
- R6: Writing 0 to the enable bit (control bit 0) during a conversion aborts it. The start bit reads 0 on the next cycle, no flag is raised and the stored result is unchanged.
- R7: The done flag (control bit 3) sets when a result is stored and clears when 1 is written to bit 3. `irq` is 1 exactly when the flag and the interrupt-enable bit (control bit 4) are both 1.
- R8: A channel written at address 1 while idle drives `chan_sel` one cycle later. One written during a conversion reads back at address 1 at once but reaches `chan_sel` only on the cycle after that conversion completes.
- R9: A read of the low byte (address 2) locks the result until a read of the high byte (address 3). A conversion that completes while the result is locked is discarded and does not set the flag.
- R10: With the adjust bit (control bit 5) at 0, address 3 returns {6'b0, result[9:8]} and address 2 returns result[7:0].
- R11: With the adjust bit at 1, address 3 returns result[9:2] and address 2 returns {result[1:0], 6'b0}. Reading only address 3 does not lock the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_tick | input | 1 | One-cycle pulse per converter clock period |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives the lock side effects) |
| bus_addr | input | 2 | Register address: 0 control, 1 channel, 2 low byte, 3 high byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| conv_value | input | 10 | Converter output, sampled on the completing tick |
| chan_sel | output | CH_W | Active channel for the analog multiplexer |
| irq | output | 1 | Completion interrupt |

## Verification
All register state changes on the clock edge that carries the write, the read strobe or the completing tick. The flag, the result bytes and `irq` are therefore visible from one time step after that edge, and `chan_sel` follows on the edge after its write or after the completion. The bench holds a behavioural model that tracks the remaining ticks with its own counter. It compares read data, `irq` and `chan_sel` one nanosecond after every rising edge, and it counts the cycles to the flag so that the 13-tick and 25-tick spans are checked exactly.

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl #(
  parameter int CH_W     = 3,
  parameter int NORM_CYC = 13,
  parameter int INIT_CYC = 25
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adc_tick,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [1:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [9:0]      conv_value,
  output logic [CH_W-1:0] chan_sel,
  output logic            irq
);
  localparam int CNT_W = $clog2(INIT_CYC);
  localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(NORM_CYC - 1);
  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYC - 1);
  localparam int B_EN = 0, B_GO = 1, B_FR = 2, B_DONE = 3, B_IE = 4, B_LADJ = 5;

  logic en_q, fr_q, flag_q, ie_q, ladj_q, busy_q, init_q, long_q, lock_q;
  logic [CNT_W-1:0] cnt_q;
  logic [9:0]       res_q;
  logic [CH_W-1:0]  ch_req_q, ch_act_q;

  logic wr_ctrl, wr_chan, rd_lo, rd_hi;
  logic en_nxt, init_nxt, cnt_last, done, store, start;
  logic [CH_W-1:0] ch_nxt;

  assign wr_ctrl  = bus_wr && bus_addr == 2'd0;
  assign wr_chan  = bus_wr && bus_addr == 2'd1;
  assign rd_lo    = bus_rd && bus_addr == 2'd2;
  assign rd_hi    = bus_rd && bus_addr == 2'd3;
  assign en_nxt   = wr_ctrl ? bus_wdata[B_EN] : en_q;
  assign init_nxt = (en_nxt && !en_q) || (init_q && en_nxt);
  assign cnt_last = cnt_q == (long_q ? INIT_LAST : NORM_LAST);
  assign done     = busy_q && adc_tick && cnt_last && en_nxt;
  assign store    = done && !lock_q;
  assign start    = !busy_q && wr_ctrl && bus_wdata[B_GO] && en_nxt;
  assign ch_nxt   = wr_chan ? bus_wdata[CH_W-1:0] : ch_req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; fr_q <= 1'b0; ie_q <= 1'b0; ladj_q <= 1'b0;
      flag_q <= 1'b0; init_q <= 1'b0; lock_q <= 1'b0;
      res_q <= '0; ch_req_q <= '0; ch_act_q <= '0;
    end else begin
      en_q   <= en_nxt;
      init_q <= start ? 1'b0 : init_nxt;
      if (wr_ctrl) begin
        fr_q   <= bus_wdata[B_FR];
        ie_q   <= bus_wdata[B_IE];
        ladj_q <= bus_wdata[B_LADJ];
      end
      if (store) flag_q <= 1'b1;
      else if (wr_ctrl && bus_wdata[B_DONE]) flag_q <= 1'b0;
      if (store) res_q <= conv_value;
      if (rd_lo) lock_q <= 1'b1;
      else if (rd_hi) lock_q <= 1'b0;
      ch_req_q <= ch_nxt;
      if (!busy_q || done) ch_act_q <= ch_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; cnt_q <= '0; long_q <= 1'b0;
    end else if (!en_nxt) begin
      busy_q <= 1'b0; cnt_q <= '0;
    end else if (done) begin
      busy_q <= fr_q; cnt_q <= '0; long_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1; cnt_q <= '0; long_q <= init_nxt;
    end else if (busy_q && adc_tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  logic [7:0] ch_rd;
  always_comb begin
    ch_rd = '0;
    ch_rd[CH_W-1:0] = ch_req_q;
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {2'b00, ladj_q, ie_q, flag_q, fr_q, busy_q, en_q} & 8'hFF;
      2'd1:    bus_rdata = ch_rd;
      2'd2:    bus_rdata = ladj_q ? {res_q[1:0], 6'b0} : res_q[7:0];
      default: bus_rdata = ladj_q ? res_q[9:2] : {6'b0, res_q[9:8]};
    endcase
    if (bus_addr == 2'd0)
      bus_rdata = {2'b00, ladj_q, ie_q, flag_q, fr_q, busy_q, en_q};
  end

  assign chan_sel = ch_act_q;
  assign irq      = flag_q && ie_q;
endmodule

module adc_seq_ctrl_chk #(
  parameter int CH_W  = 3,
  parameter int CNT_W = 5,
  parameter int LAST  = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            adc_tick,
  input logic            bus_wr,
  input logic [1:0]      bus_addr,
  input logic [7:0]      bus_wdata,
  input logic            busy_q,
  input logic            fr_q,
  input logic            flag_q,
  input logic            lock_q,
  input logic [9:0]      res_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CH_W-1:0] chan_sel
);
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && !bus_wdata[0]) |=> !busy_q);
  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(res_q));
  p_chan_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !adc_tick) |=> $stable(chan_sel));
  p_flag_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(busy_q && adc_tick));
  p_freerun_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && fr_q && !(bus_wr && bus_addr == 2'd0)) |=> busy_q);
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LAST));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CH_W(CH_W), .CNT_W(CNT_W), .LAST(INIT_CYC - 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_tick(adc_tick), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy_q(busy_q), .fr_q(fr_q),
  .flag_q(flag_q), .lock_q(lock_q), .res_q(res_q), .cnt_q(cnt_q), .chan_sel(chan_sel)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0, adc_tick = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [9:0] conv_value = 10'd0;
  logic [2:0] chan_sel;
  logic irq;

  int checks = 0, failures = 0, cyc = 0, tdiv = 1, wd = 0;
  string cur = "R1";

  always #2.5 clk = ~clk;

  adc_seq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .adc_tick(adc_tick), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_value(conv_value), .chan_sel(chan_sel), .irq(irq));

  // behavioural reference model: counts remaining ticks down
  bit m_en, m_fr, m_flag, m_ie, m_ladj, m_lock, m_arm, m_run;
  int m_left;
  logic [9:0] m_res;
  logic [2:0] m_chreq, m_chact;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_fr = 0; m_flag = 0; m_ie = 0; m_ladj = 0; m_lock = 0; m_arm = 0;
      m_run = 0; m_left = 0; m_res = 0; m_chreq = 0; m_chact = 0;
    end else begin
      bit wc, en_n, arm_n, fin, go;
      logic [2:0] chn;
      wc    = bus_wr && bus_addr == 0;
      en_n  = wc ? bus_wdata[0] : m_en;
      arm_n = en_n && (!m_en || m_arm);
      fin   = m_run && adc_tick && m_left == 1 && en_n;
      go    = !m_run && wc && bus_wdata[1] && en_n;
      chn   = (bus_wr && bus_addr == 1) ? bus_wdata[2:0] : m_chreq;
      if (!m_run || fin) m_chact = chn;
      m_chreq = chn;
      if (fin && !m_lock) begin m_res = conv_value; m_flag = 1; end
      else if (wc && bus_wdata[3]) m_flag = 0;
      if (bus_rd && bus_addr == 2) m_lock = 1;
      else if (bus_rd && bus_addr == 3) m_lock = 0;
      if (!en_n) m_run = 0;
      else if (fin) begin m_run = m_fr; m_left = 13; end
      else if (go) begin m_run = 1; m_left = arm_n ? 25 : 13; end
      else if (m_run && adc_tick) m_left--;
      m_arm = go ? 0 : arm_n;
      if (wc) begin m_fr = bus_wdata[2]; m_ie = bus_wdata[4]; m_ladj = bus_wdata[5]; end
      m_en = en_n;
    end
  end

  function automatic logic [7:0] mrd(input logic [1:0] a);
    case (a)
      0: return {2'b00, m_ladj, m_ie, m_flag, m_fr, m_run, m_en};
      1: return {5'b0, m_chreq};
      2: return m_ladj ? {m_res[1:0], 6'b0} : m_res[7:0];
      default: return m_ladj ? m_res[9:2] : {6'b0, m_res[9:8]};
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=0x%0h expected=0x%0h", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    adc_tick = (cyc % tdiv) == 0;
    @(posedge clk); #1; cyc++;
    if (rst_n) begin
      chk({cur, " model rdata"}, bus_rdata, mrd(bus_addr));
      chk({cur, " model irq"}, irq, m_flag && m_ie);
      chk({cur, " model chan_sel"}, chan_sel, m_chact);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; step(); bus_wr = 0; bus_addr = 0;
  endtask

  task automatic rd(input logic [1:0] a, input string req, input int exp);
    bus_addr = a; bus_rd = 1; #1; chk(req, bus_rdata, exp); step(); bus_rd = 0; bus_addr = 0;
  endtask

  task automatic wait_flag(output int n);
    bus_addr = 0; n = 0;
    for (int i = 0; i < 400; i++) begin
      step(); n++;
      if (bus_rdata[3]) return;
    end
    chk({cur, " flag timeout"}, 0, 1);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) step();
    rst_n = 1; step();
    cur = "R1";
    rd(0, "R1 ctrl reset", 8'h00); rd(1, "R1 chan reset", 8'h00);
    rd(2, "R1 lo reset", 8'h00); rd(3, "R1 hi reset", 8'h00);
    chk("R1 irq reset", irq, 0); chk("R1 chan_sel reset", chan_sel, 0);

    cur = "R3"; conv_value = 10'h2A5;
    wr(0, 8'h03); wait_flag(n); chk("R3 enable+start 25 ticks", n, 25);
    cur = "R4"; rd(0, "R4 start cleared after single", 8'h09);
    cur = "R10"; rd(2, "R10 right lo", 8'hA5); rd(3, "R10 right hi", 8'h02);
    cur = "R7"; wr(0, 8'h09); rd(0, "R7 flag w1c", 8'h01);

    cur = "R2"; conv_value = 10'h155;
    wr(0, 8'h03); chk("R4 start reads 1 while busy", bus_rdata[1], 1);
    wr(0, 8'h03); wait_flag(n); chk("R2 normal 12+1 ticks after ignored restart", n + 1, 13);
    cur = "R4"; repeat (20) step(); rd(0, "R4 no auto restart", 8'h09);

    cur = "R7"; wr(0, 8'h11); chk("R7 irq with flag and ie", irq, 1);
    wr(0, 8'h19); chk("R7 irq cleared with flag", irq, 0);

    cur = "R11"; wr(0, 8'h31); conv_value = 10'h3C7;
    wr(0, 8'h33); wait_flag(n); chk("R2 13 ticks", n, 13);
    rd(3, "R11 left hi", 8'hF1);
    conv_value = 10'h0FE; wr(0, 8'h3B); wait_flag(n); chk("R11 hi-only read leaves result unlocked", n, 13);
    rd(3, "R11 left hi new", 8'h3F); rd(2, "R11 left lo", 8'h80); rd(3, "R11 unlock", 8'h3F);
    wr(0, 8'h19);

    cur = "R9"; rd(2, "R9 lo locks", 8'hFE); conv_value = 10'h301;
    wr(0, 8'h03); repeat (20) step();
    rd(0, "R9 discarded no flag", 8'h01); rd(3, "R9 hi old value", 8'h00);
    rd(2, "R9 lo old value", 8'hFE); rd(3, "R9 unlock", 8'h00);
    wr(0, 8'h03); wait_flag(n); chk("R9 stores after unlock", n, 13);
    rd(2, "R9 new lo", 8'h01); rd(3, "R9 new hi", 8'h03); wr(0, 8'h09);

    cur = "R8"; wr(1, 8'h03); chk("R8 idle chan applies", chan_sel, 3);
    wr(0, 8'h03); repeat (4) step(); wr(1, 8'h06);
    chk("R8 chan held during conversion", chan_sel, 3);
    rd(1, "R8 pending readback", 8'h06);
    wait_flag(n); step(); chk("R8 chan applied after completion", chan_sel, 6); wr(0, 8'h09);

    cur = "R6"; conv_value = 10'h111; wr(0, 8'h03); repeat (5) step();
    wr(0, 8'h00); rd(0, "R6 abort clears start", 8'h00);
    repeat (30) step(); rd(0, "R6 no flag", 8'h00);
    rd(2, "R6 result kept lo", 8'h01); rd(3, "R6 result kept hi", 8'h03);
    cur = "R3"; wr(0, 8'h01); step(); wr(0, 8'h03); wait_flag(n);
    chk("R3 separate start after enable 25 ticks", n, 25);
    rd(2, "R3 lo", 8'h11); rd(3, "R3 hi", 8'h01); wr(0, 8'h09);

    cur = "R5"; tdiv = 2; conv_value = 10'h0AA;
    wr(0, 8'h07); wait_flag(n);
    wr(0, 8'h0D); conv_value = 10'h0BB; wait_flag(n);
    chk("R5 back-to-back 13 ticks at div2", n + 1, 26);
    rd(0, "R5 start stays set", 8'h0F);
    rd(2, "R5 second result lo", 8'hBB); rd(3, "R5 second hi", 8'h00);
    wr(0, 8'h09); wait_flag(n);
    rd(0, "R5 stops after free-run cleared", 8'h09);
    tdiv = 1; repeat (5) step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule